// File: doc/BRIEF.md
# Pipelined External Cache Lookup Sequencer

This block puts accesses to a large off-chip cache, built from a separate tag RAM and a separate data SRAM, into a fixed pipeline. A requester on the integer side or the floating-point side presents an address together with a one-bit source code. The block accepts a new request on every clock. It drives the tag RAM, compares the stored tag against the address, and spends one stage doing nothing so that the compare result has a full cycle to reach the data SRAM. It then reads the data SRAM and hands the word back with a hit flag.

The schedule is fixed at five stages. Every access comes out exactly five clocks after it was presented, and up to five accesses can be in flight at once. The address and source code travel alongside the access and come back with the data. The response valid is steered to the port of the side that issued the request. Miss refill, coherence and writes are outside this block. The tag check is the whole of the lookup.

Top module: `xcache_pipe`

## Requirements
- R1: While reset is held, and on the first cycle after it, `tag_en`, `dat_en`, `rsp_valid`, `rsp_int_valid` and `rsp_fp_valid` are all low.
- R2: One cycle after a request is presented with `req_valid` high, `tag_en` is high and `tag_idx` equals the set index of that address. The set index is `addr[IDX_W+OFS_W-1:OFS_W]`.
- R3: The tag RAM returns its entry in the cycle after `tag_en`. An access hits only when the entry's valid bit is 1 and its stored tag equals `addr[ADDR_W-1:IDX_W+OFS_W]`. An entry whose valid bit is 0 misses even when its tag matches.
- R4: `dat_en` rises exactly three cycles after the `tag_en` of the same access, with the same index, and only when that access hit. The cycle in between carries the compare result and does no other work.
- R5: `rsp_valid` is high exactly five cycles after the request was presented. `rsp_addr` and `rsp_src` then equal the request's address and source.
- R6: On a hit, `rsp_hit` is 1 and `rsp_data` is the data SRAM word at the set index. On a miss, `rsp_hit` is 0 and `rsp_data` is all zeros.
- R7: `rsp_int_valid` is high for responses with source code 0 (integer). `rsp_fp_valid` is high for responses with source code 1 (floating point). At most one of them is high, and only together with `rsp_valid`.
- R8: Requests on consecutive cycles all come back, one per cycle, in issue order, with no loss. This holds with five in flight at once.
- R9: A cycle with `req_valid` low gives no response five cycles later, and it does not disturb the accesses on either side of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_src | input | 1 | Requester: 0 integer, 1 floating point |
| req_addr | input | ADDR_W | Byte address of the access |
| tag_en | output | 1 | Tag RAM read strobe (stage 1) |
| tag_idx | output | IDX_W | Tag RAM set index |
| tag_rd_vld | input | 1 | Valid bit of the entry read, one cycle after `tag_en` |
| tag_rd_tag | input | TAG_W | Stored tag of the entry read |
| dat_en | output | 1 | Data SRAM read strobe (stage 4, hits only) |
| dat_idx | output | IDX_W | Data SRAM index |
| dat_rd | input | DATA_W | Data SRAM word, same cycle as `dat_en` |
| rsp_valid | output | 1 | A response is presented (stage 5) |
| rsp_src | output | 1 | Requester code of the response |
| rsp_addr | output | ADDR_W | Address of the response |
| rsp_hit | output | 1 | Tag matched, so `rsp_data` is usable |
| rsp_data | output | DATA_W | Returned word, zero on a miss |
| rsp_int_valid | output | 1 | Response belongs to the integer side |
| rsp_fp_valid | output | 1 | Response belongs to the floating-point side |

## Verification
The bench builds the block with `ADDR_W=16`, `IDX_W=4`, `OFS_W=3` and `DATA_W=32`. That leaves 16 sets and a 9-bit tag. Random addresses therefore fall on the same set many times within five-deep bursts, and both hits and misses come up often. The small tag space also makes it cheap to hit the corner where a stored tag matches but its valid bit is clear.

// File: rtl/xcp_pkg.sv
package xcp_pkg;
  typedef enum logic {
    XCP_INT = 1'b0,
    XCP_FP  = 1'b1
  } xcp_src_e;

  localparam int XCP_STAGES = 5;
endpackage

// File: rtl/xcp_carrier.sv
module xcp_carrier #(
  parameter int PW    = 8,
  parameter int DEPTH = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_vld,
  input  logic [PW-1:0]               in_pl,
  output logic [DEPTH-1:0]            vld_o,
  output logic [DEPTH-1:0][PW-1:0]    pl_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_o[g] <= 1'b0;
          pl_o[g]  <= '0;
        end else begin
          vld_o[g] <= in_vld;
          pl_o[g]  <= in_pl;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_o[g] <= 1'b0;
          pl_o[g]  <= '0;
        end else begin
          vld_o[g] <= vld_o[g-1];
          pl_o[g]  <= pl_o[g-1];
        end
      end
    end
  end
endmodule

// File: rtl/xcp_tag_check.sv
module xcp_tag_check #(
  parameter int TAG_W = 8
) (
  input  logic             ent_vld,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0] want_tag,
  output logic             hit
);
  always_comb hit = ent_vld && (ent_tag == want_tag);
endmodule

// File: rtl/xcp_resp_steer.sv
module xcp_resp_steer
  import xcp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     vld,
  input  xcp_src_e src,
  output logic     int_v,
  output logic     fp_v
);
  always_comb begin
    int_v = vld && (src == XCP_INT);
    fp_v  = vld && (src == XCP_FP);
  end

  assert_steer_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_v, fp_v}) && ((int_v || fp_v) == vld));
endmodule

// File: rtl/xcache_pipe.sv
module xcache_pipe
  import xcp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 6,
  parameter int OFS_W  = 3,
  parameter int DATA_W = 64,
  localparam int TAG_W = ADDR_W - IDX_W - OFS_W,
  localparam int PW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_src,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              tag_en,
  output logic [IDX_W-1:0]  tag_idx,
  input  logic              tag_rd_vld,
  input  logic [TAG_W-1:0]  tag_rd_tag,
  output logic              dat_en,
  output logic [IDX_W-1:0]  dat_idx,
  input  logic [DATA_W-1:0] dat_rd,
  output logic              rsp_valid,
  output logic              rsp_src,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_int_valid,
  output logic              rsp_fp_valid
);
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W+OFS_W-1:OFS_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W+OFS_W];
  endfunction

  // Stage carrier: index 0 is stage 1 ... index 4 is stage 5
  logic [XCP_STAGES-1:0]         st_vld;
  logic [XCP_STAGES-1:0][PW-1:0] st_pl;

  xcp_carrier #(.PW(PW), .DEPTH(XCP_STAGES)) u_carrier (
    .clk   (clk),
    .rst_n (rst_n),
    .in_vld(req_valid),
    .in_pl ({req_src, req_addr}),
    .vld_o (st_vld),
    .pl_o  (st_pl)
  );

  // Stage 1: present index to the tag RAM
  always_comb begin
    tag_en  = st_vld[0];
    tag_idx = f_idx(st_pl[0][ADDR_W-1:0]);
  end

  // Stage 2: tag RAM entry arrives, compare
  logic s2_hit;
  xcp_tag_check #(.TAG_W(TAG_W)) u_cmp (
    .ent_vld (tag_rd_vld),
    .ent_tag (tag_rd_tag),
    .want_tag(f_tag(st_pl[1][ADDR_W-1:0])),
    .hit     (s2_hit)
  );

  // Stage 3 carries the compare result only; stage 4 uses it
  logic s3_hit, s4_hit;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s3_hit <= 1'b0;
      s4_hit <= 1'b0;
    end else begin
      s3_hit <= st_vld[1] && s2_hit;
      s4_hit <= s3_hit;
    end
  end

  // Stage 4: data SRAM read, only for hits
  always_comb begin
    dat_en  = st_vld[3] && s4_hit;
    dat_idx = f_idx(st_pl[3][ADDR_W-1:0]);
  end

  // Stage 5: response registers
  logic              s5_hit;
  logic [DATA_W-1:0] s5_data;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s5_hit  <= 1'b0;
      s5_data <= '0;
    end else begin
      s5_hit  <= dat_en;
      s5_data <= dat_en ? dat_rd : '0;
    end
  end

  always_comb begin
    rsp_valid = st_vld[4];
    rsp_src   = st_pl[4][ADDR_W];
    rsp_addr  = st_pl[4][ADDR_W-1:0];
    rsp_hit   = s5_hit;
    rsp_data  = s5_data;
  end

  xcp_resp_steer u_steer (
    .clk  (clk),
    .rst_n(rst_n),
    .vld  (rsp_valid),
    .src  (xcp_src_e'(rsp_src)),
    .int_v(rsp_int_valid),
    .fp_v (rsp_fp_valid)
  );

  assert_tag_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> tag_en && (tag_idx == f_idx($past(req_addr))));

  assert_idle_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dat_en |-> $past(tag_en, 3) && ($past(tag_idx, 3) == dat_idx));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid, 5) && (rsp_addr == $past(req_addr, 5))
                  && (rsp_src == $past(req_src, 5)));

  assert_hit_follows_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit == $past(dat_en)));

  assert_bubble_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid, 5) |-> !rsp_valid);
endmodule

// File: tb/sim_xcache_pipe.sv
module sim_xcache_pipe;
  localparam int PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 4;
  localparam int OW = 3;
  localparam int DW = 32;
  localparam int TW = AW - IW - OW;
  localparam int SETS = 1 << IW;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          req_valid = 0;
  logic          req_src = 0;
  logic [AW-1:0] req_addr = '0;
  logic          tag_en, dat_en, rsp_valid, rsp_src, rsp_hit;
  logic          rsp_int_valid, rsp_fp_valid;
  logic [IW-1:0] tag_idx, dat_idx;
  logic          tag_rd_vld;
  logic [TW-1:0] tag_rd_tag;
  logic [DW-1:0] dat_rd, rsp_data;
  logic [AW-1:0] rsp_addr;

  logic [TW:0]   tmem [SETS];
  logic [DW-1:0] dmem [SETS];
  logic [TW:0]   tq;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  bit h_v [8];
  bit h_s [8];
  logic [AW-1:0] h_a [8];

  always #(PERIOD/2) clk = ~clk;

  xcache_pipe #(.ADDR_W(AW), .IDX_W(IW), .OFS_W(OW), .DATA_W(DW)) u0 (
    .clk, .rst_n, .req_valid, .req_src, .req_addr,
    .tag_en, .tag_idx, .tag_rd_vld, .tag_rd_tag,
    .dat_en, .dat_idx, .dat_rd,
    .rsp_valid, .rsp_src, .rsp_addr, .rsp_hit, .rsp_data,
    .rsp_int_valid, .rsp_fp_valid
  );

  // synchronous tag RAM, flow-through data SRAM
  always @(posedge clk) if (tag_en) tq <= tmem[tag_idx];
  assign tag_rd_vld = tq[TW];
  assign tag_rd_tag = tq[TW-1:0];
  assign dat_rd = dmem[dat_idx];

  function automatic int set_of(input logic [AW-1:0] a);
    return int'(a >> OW) % SETS;
  endfunction

  function automatic bit hit_of(input logic [AW-1:0] a);
    logic [TW:0] e;
    e = tmem[set_of(a)];
    return (e[TW] == 1'b1) && (int'(e[TW-1:0]) == int'(a >> (OW + IW)));
  endfunction

  function automatic logic [AW-1:0] mk(input int tg, input int st, input int of);
    return AW'((tg << (OW + IW)) | (st << OW) | of);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic observe();
    int p1, p4, p5;
    bit e_hit;
    p1 = (cyc + 7) % 8;
    p4 = (cyc + 4) % 8;
    p5 = (cyc + 3) % 8;
    chk(tag_en == h_v[p1], "R2", "tag_en", tag_en, h_v[p1]);
    if (h_v[p1]) chk(int'(tag_idx) == set_of(h_a[p1]), "R2", "tag_idx", tag_idx, set_of(h_a[p1]));
    e_hit = h_v[p4] && hit_of(h_a[p4]);
    chk(dat_en == e_hit, "R4", "dat_en", dat_en, e_hit);
    if (e_hit) chk(int'(dat_idx) == set_of(h_a[p4]), "R4", "dat_idx", dat_idx, set_of(h_a[p4]));
    chk(rsp_valid == h_v[p5], "R9", "rsp_valid", rsp_valid, h_v[p5]);
    if (h_v[p5]) begin
      e_hit = hit_of(h_a[p5]);
      chk(rsp_addr == h_a[p5], "R5", "rsp_addr", rsp_addr, h_a[p5]);
      chk(rsp_src == h_s[p5], "R5", "rsp_src", rsp_src, h_s[p5]);
      chk(rsp_hit == e_hit, "R3", "rsp_hit", rsp_hit, e_hit);
      if (e_hit) chk(rsp_data == dmem[set_of(h_a[p5])], "R6", "hit data", rsp_data, dmem[set_of(h_a[p5])]);
      else       chk(rsp_data == '0, "R6", "miss data", rsp_data, 0);
      chk(rsp_int_valid == !h_s[p5], "R7", "int_valid", rsp_int_valid, !h_s[p5]);
      chk(rsp_fp_valid == h_s[p5], "R7", "fp_valid", rsp_fp_valid, h_s[p5]);
    end else begin
      chk(!rsp_int_valid && !rsp_fp_valid, "R7", "steer idle", {rsp_int_valid, rsp_fp_valid}, 0);
    end
  endtask

  task automatic step(input bit v, input bit s, input logic [AW-1:0] a);
    @(negedge clk);
    observe();
    req_valid = v;
    req_src = s;
    req_addr = a;
    h_v[cyc % 8] = v;
    h_s[cyc % 8] = s;
    h_a[cyc % 8] = a;
    cyc++;
  endtask

  task automatic rnd_req(input int pct_valid);
    int st, tg;
    st = int'($urandom % SETS);
    tg = ($urandom % 100 < 60) ? int'(tmem[st][TW-1:0]) : int'($urandom % (1 << TW));
    step($urandom % 100 < pct_valid, $urandom % 2, mk(tg, st, int'($urandom % (1 << OW))));
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < SETS; i++) begin
      tmem[i] = {1'($urandom % 4 != 0), TW'($urandom)};
      dmem[i] = DW'($urandom);
    end
    for (int i = 0; i < 8; i++) begin
      h_v[i] = 0; h_s[i] = 0; h_a[i] = '0;
    end
    tmem[3] = {1'b0, TW'(7)};
    tmem[5] = {1'b1, TW'((1 << TW) - 1)};
    tmem[9] = {1'b1, TW'(2)};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: quiet outputs under reset
    chk(!tag_en && !dat_en && !rsp_valid && !rsp_int_valid && !rsp_fp_valid,
        "R1", "reset outputs", {tag_en, dat_en, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!tag_en && !dat_en && !rsp_valid, "R1", "post-reset outputs",
        {tag_en, dat_en, rsp_valid}, 0);
    // R3: matching tag in an invalid entry is a miss
    step(1, 0, mk(7, 3, 0));
    // R6: all-ones tag hit, floating-point side
    step(1, 1, mk((1 << TW) - 1, 5, 7));
    // R8: back-to-back same set, alternating hit/miss
    step(1, 0, mk(2, 9, 1));
    step(1, 1, mk(3, 9, 2));
    step(1, 0, mk(2, 9, 3));
    step(1, 1, mk(3, 9, 4));
    step(1, 0, mk(2, 9, 5));
    // R9: bubbles between accesses
    step(0, 0, mk(2, 9, 0));
    step(1, 1, mk(2, 9, 6));
    step(0, 1, '1);
    step(0, 0, '0);
    step(1, 0, mk(3, 9, 0));
    // random traffic, dense then sparse
    for (int i = 0; i < 400; i++) rnd_req(90);
    for (int i = 0; i < 200; i++) rnd_req(40);
    for (int i = 0; i < 8; i++) step(0, 0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule